// File: doc/BRIEF.md
# Register-Programmed Serial Peripheral Interface Master

This block is a serial peripheral interface master that software runs through a small word-addressed register bus. Software sets up a control word (character length, clock divider, bit order, internal loopback) and then writes one character of 4 to 16 bits, or exactly 32 bits, into the transmit register. The block shifts the character out on `sck`/`mosi` while it samples `miso`. When the last bit is done, it places the received character, right-justified, in the receive register.

Two sticky status flags tell software what state the block is in. One flag means "a received character is waiting". The other means "the transmitter can take a new character". Software clears each flag by writing a one to its bit. An interrupt line is raised when any flag is set and its enable bit in the mask register is also set. Chip selects are outside the block; software drives them with other logic. The transmit side holds one character and has no deeper queue.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, the control word reads 0, the status word reads 0x0000_0100 (only the transmitter-free flag, bit 8, is set), and the mask and receive registers read 0. `sck` and `irq` are low.
- R2: The control word's length field is bits 23:20. A value of 0 selects 32 bits. A value n from 3 to 15 selects n+1 bits. Values 1 and 2 select the minimum of 4 bits.
- R3: A control-word write made while the enable bit (bit 24) is set leaves the length field unchanged. The write still updates all other fields.
- R4: With bit 26 clear, bits are shifted out least-significant first, starting from bit 0. With bit 26 set, the first bit shifted is bit (length-1), and shifting proceeds downward. Each received bit is stored at the same position as the bit that was sent alongside it.
- R5: `sck` idles low. Its period is 4 x (divider+1) system clocks, where the divider is control bits 19:16. `mosi` changes only while `sck` is low, and `miso` is sampled on the rising edge of `sck`.
- R6: Characters are right-justified. Transmit bits above the character length are never sent. Receive bits above the length read as 0.
- R7: When control bit 30 is set, the received data is taken from the block's own `mosi` instead of the `miso` pin, so the receive register equals the transmitted character.
- R8: The transmitter-free flag (status bit 8) goes low when a character starts and stays low while it is being shifted. In the cycle the shifter finishes, that flag and the received-character flag (status bit 9) are both set, and the receive register is loaded.
- R9: Writing a one to a status bit clears that bit, and writing a zero has no effect. If a hardware set happens in the same cycle as the clear, the set wins.
- R10: `irq` is high exactly when a status bit is set and the mask bit at the same position (mask register bits 9:8) is also set.
- R11: A write to the transmit register starts a character only if both enable (bit 24) and master (bit 25) are set and the shifter is idle. In every other case the write is ignored.
- R12: Reading the receive register does not clear the received-character flag. If a new character completes while that flag is still set, the new character replaces the receive data.

Word addresses on `reg_addr`: 0 = control, 1 = status, 2 = mask, 3 = command (a plain 32-bit storage word), 4 = transmit, 5 = receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Write qualifier for the access |
| reg_addr | input | 3 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Masked status interrupt |

## Verification
The hardest situations to reach from the ports are the ones where two events land close together. One case is a status write that lands in the same cycle as the shifter's final edge. Another is a transmit write that arrives while a character is still being shifted. The bench reaches the second case by starting a slow transfer (divider 3) and issuing a second transmit write two cycles later. It then confirms that only the first character's bits show up on the wire and in the receive register. Bit order and right-justification are checked against a bench-side slave model. That model records `mosi` on every `sck` rise and feeds `miso` from a reply word on every fall.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned LEN_W = 4;
  localparam int unsigned PM_W  = 4;
  localparam int unsigned CNT_W = $clog2(DW) + 1;
  localparam int unsigned IDX_W = $clog2(DW);

  localparam logic [2:0] W_CTRL = 3'd0;
  localparam logic [2:0] W_STAT = 3'd1;
  localparam logic [2:0] W_MASK = 3'd2;
  localparam logic [2:0] W_CMD  = 3'd3;
  localparam logic [2:0] W_TX   = 3'd4;
  localparam logic [2:0] W_RX   = 3'd5;

  localparam int unsigned B_LOOP = 30;
  localparam int unsigned B_MSBF = 26;
  localparam int unsigned B_MAST = 25;
  localparam int unsigned B_EN   = 24;
  localparam int unsigned B_LEN  = 20;
  localparam int unsigned B_PM   = 16;
  localparam int unsigned B_RXF  = 9;
  localparam int unsigned B_TXF  = 8;

  // Length code to character bits: 0 -> 32, 1..2 -> 4, n -> n+1
  function automatic logic [CNT_W-1:0] char_bits(input logic [LEN_W-1:0] code);
    if (code == '0)        return CNT_W'(DW);
    else if (code < 4'd3)  return CNT_W'(4);
    else                   return CNT_W'(code) + CNT_W'(1);
  endfunction

  function automatic logic [DW-1:0] low_mask(input logic [CNT_W-1:0] n);
    if (n >= CNT_W'(DW)) return '1;
    return (DW'(1) << n) - DW'(1);
  endfunction

  // Half SCK period minus one: 2*(pm+1)-1
  function automatic logic [PM_W:0] half_m1(input logic [PM_W-1:0] pm);
    return {pm, 1'b1};
  endfunction

  // Register bit addressed by shift step k
  function automatic logic [IDX_W-1:0] bit_pos(input logic [IDX_W-1:0] k,
                                               input logic [CNT_W-1:0] n,
                                               input logic msb);
    logic [CNT_W-1:0] r;
    r = msb ? (n - CNT_W'(1) - CNT_W'(k)) : CNT_W'(k);
    return r[IDX_W-1:0];
  endfunction
endpackage

// File: rtl/spi_host_tick.sv
module spi_host_tick
  import spi_host_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PM_W-1:0] pm,
  output logic            tick
);
  logic [PM_W:0] cnt_q;
  logic [PM_W:0] lim;

  assign lim  = half_m1(pm);
  assign tick = run && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_host_shift.sv
module spi_host_shift
  import spi_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DW-1:0]    tx_in,
  input  logic [CNT_W-1:0] nbits,
  input  logic             msb_first,
  input  logic             tick,
  input  logic             miso_in,
  output logic             sck,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    rx_data,
  output logic [DW-1:0]    sh_data
);
  logic [DW-1:0]    txd_q, rxd_q;
  logic [IDX_W-1:0] k_q;
  logic [CNT_W-1:0] n_q;
  logic             msb_q, sck_q, busy_q;
  logic             last;
  logic [IDX_W-1:0] idx;

  assign idx  = bit_pos(k_q, n_q, msb_q);
  assign last = (CNT_W'(k_q) == (n_q - CNT_W'(1)));
  assign done = busy_q && tick && sck_q && last;
  assign mosi = busy_q && txd_q[idx];
  assign sck  = sck_q;
  assign busy = busy_q;
  assign rx_data = rxd_q;
  assign sh_data = txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q  <= '0;
      rxd_q  <= '0;
      k_q    <= '0;
      n_q    <= CNT_W'(DW);
      msb_q  <= 1'b0;
      sck_q  <= 1'b0;
      busy_q <= 1'b0;
    end else if (start) begin
      txd_q  <= tx_in & low_mask(nbits);
      rxd_q  <= '0;
      k_q    <= '0;
      n_q    <= nbits;
      msb_q  <= msb_first;
      sck_q  <= 1'b0;
      busy_q <= 1'b1;
    end else if (busy_q && tick) begin
      if (!sck_q) begin
        sck_q      <= 1'b1;
        rxd_q[idx] <= miso_in;
      end else if (last) begin
        sck_q  <= 1'b0;
        busy_q <= 1'b0;
      end else begin
        sck_q <= 1'b0;
        k_q   <= k_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_host_evt.sv
module spi_host_evt (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_wr,
  input  logic [1:0] clr_bits,   // [1]=rx ready, [0]=tx free
  input  logic       done,
  input  logic       start,
  input  logic [1:0] mask,
  output logic       rx_rdy,
  output logic       tx_free,
  output logic       irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rdy  <= 1'b0;
      tx_free <= 1'b1;
    end else begin
      if (done)                         rx_rdy <= 1'b1;
      else if (clr_wr && clr_bits[1])   rx_rdy <= 1'b0;

      if (done)                         tx_free <= 1'b1;
      else if (start)                   tx_free <= 1'b0;
      else if (clr_wr && clr_bits[0])   tx_free <= 1'b0;
    end
  end

  assign irq = |({rx_rdy, tx_free} & mask);
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_en,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  output logic          irq
);
  logic             loop_q, msbf_q, mast_q, en_q;
  logic [LEN_W-1:0] len_q;
  logic [PM_W-1:0]  pm_q;
  logic [1:0]       mask_q;
  logic [31:0]      cmd_q;
  logic [DW-1:0]    rx_q;

  logic             wr, tx_start, tick, busy, done, miso_in;
  logic             rx_rdy, tx_free, mosi_i;
  logic [DW-1:0]    rx_data, sh_data;
  logic [CNT_W-1:0] nbits;

  assign wr       = reg_en && reg_we;
  assign tx_start = wr && (reg_addr == W_TX) && en_q && mast_q && !busy;
  assign nbits    = char_bits(len_q);
  assign miso_in  = loop_q ? mosi_i : miso;
  assign mosi     = mosi_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q <= 1'b0; msbf_q <= 1'b0; mast_q <= 1'b0; en_q <= 1'b0;
      len_q  <= '0;   pm_q   <= '0;   mask_q <= '0;   cmd_q <= '0;
      rx_q   <= '0;
    end else begin
      if (wr && reg_addr == W_CTRL) begin
        loop_q <= reg_wdata[B_LOOP];
        msbf_q <= reg_wdata[B_MSBF];
        mast_q <= reg_wdata[B_MAST];
        en_q   <= reg_wdata[B_EN];
        pm_q   <= reg_wdata[B_PM +: PM_W];
        if (!en_q) len_q <= reg_wdata[B_LEN +: LEN_W];
      end
      if (wr && reg_addr == W_MASK) mask_q <= reg_wdata[B_RXF:B_TXF];
      if (wr && reg_addr == W_CMD)  cmd_q  <= reg_wdata;
      if (done)                     rx_q   <= rx_data;
    end
  end

  spi_host_tick u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .pm(pm_q), .tick(tick)
  );

  spi_host_shift u_shift (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .tx_in(reg_wdata),
    .nbits(nbits), .msb_first(msbf_q), .tick(tick), .miso_in(miso_in),
    .sck(sck), .mosi(mosi_i), .busy(busy), .done(done),
    .rx_data(rx_data), .sh_data(sh_data)
  );

  spi_host_evt u_evt (
    .clk(clk), .rst_n(rst_n),
    .clr_wr(wr && reg_addr == W_STAT), .clr_bits(reg_wdata[B_RXF:B_TXF]),
    .done(done), .start(tx_start), .mask(mask_q),
    .rx_rdy(rx_rdy), .tx_free(tx_free), .irq(irq)
  );

  always_comb begin
    unique case (reg_addr)
      W_CTRL:  reg_rdata = {1'b0, loop_q, 3'b000, msbf_q, mast_q, en_q, len_q, pm_q, 16'h0};
      W_STAT:  reg_rdata = {22'h0, rx_rdy, tx_free, 8'h0};
      W_MASK:  reg_rdata = {22'h0, mask_q, 8'h0};
      W_CMD:   reg_rdata = cmd_q;
      W_RX:    reg_rdata = rx_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        sck,
  input logic        rx_rdy,
  input logic        tx_free,
  input logic        en_q,
  input logic [3:0]  len_q,
  input logic [31:0] sh_data,
  input logic        reg_en,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [1:0]  mask_q,
  input logic        irq
);
  logic stat_clr_rx;
  assign stat_clr_rx = reg_en && reg_we && (reg_addr == 3'd1) && reg_wdata[9];

  a_r8_free_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tx_free);
  a_r8_done_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (rx_rdy && tx_free && !busy));
  a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  a_r3_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(len_q));
  a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr_rx && !done) |=> !rx_rdy);
  a_r11_busy_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sh_data));
  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 2'b00) |-> !irq);
endmodule

bind spi_host_ctrl spi_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .sck(sck),
  .rx_rdy(rx_rdy), .tx_free(tx_free), .en_q(en_q), .len_q(len_q),
  .sh_data(sh_data), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mask_q(mask_q), .irq(irq)
);

// File: tb/spi_host_ctrl_bench.sv
`timescale 1ns/1ps
module spi_host_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sck, mosi, miso, irq;

  int checks = 0, errors = 0;
  int cyc = 0, last_rise = 0, period = 0, rises = 0;
  logic [31:0] reply = '0, cap = '0;
  int slv_cnt = 0, cap_cnt = 0;

  always #2.5 clk = ~clk;

  spi_host_ctrl u_spi_host_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
  );

  // Slave model: drive next reply bit after each fall, capture mosi on rise
  assign miso = reply[slv_cnt[4:0]];
  always @(negedge sck) slv_cnt = slv_cnt + 1;
  always @(posedge sck) begin
    if (cap_cnt < 32) cap[cap_cnt] = mosi;
    cap_cnt = cap_cnt + 1;
    rises = rises + 1;
    if (last_rise != 0) period = cyc - last_rise;
    last_rise = cyc;
  end
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] ctl(input bit loop, input bit msb, input bit en,
                                      input logic [3:0] len, input logic [3:0] pm);
    return (32'(loop) << 30) | (32'(msb) << 26) | (32'd1 << 25) | (32'(en) << 24)
         | (32'(len) << 20) | (32'(pm) << 16);
  endfunction

  function automatic int nb(input logic [3:0] len);
    if (len == 0) return 32;
    if (len < 3) return 4;
    return int'(len) + 1;
  endfunction

  function automatic logic [31:0] exp_rx(input logic [31:0] rp, input int n, input bit msb);
    logic [31:0] r = '0;
    for (int k = 0; k < n; k++) r[msb ? n-1-k : k] = rp[k];
    return r;
  endfunction

  function automatic logic [31:0] exp_tx(input logic [31:0] t, input int n, input bit msb);
    logic [31:0] r = '0;
    for (int k = 0; k < n; k++) r[k] = t[msb ? n-1-k : k];
    return r;
  endfunction

  task automatic wait_free();
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd1, d);
      if (d[8]) break;
    end
  endtask

  task automatic xfer(input bit loop, input bit msb, input logic [3:0] len,
                      input logic [3:0] pm, input logic [31:0] t,
                      input logic [31:0] rp, input bit clr, output logic [31:0] rx);
    wr(3'd0, ctl(loop, msb, 1'b0, len, pm));
    wr(3'd0, ctl(loop, msb, 1'b1, len, pm));
    if (clr) wr(3'd1, 32'hFFFF_FFFF);
    reply = rp; slv_cnt = 0; cap_cnt = 0; cap = '0;
    wr(3'd4, t);
    wait_free();
    rd(3'd5, rx);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); check(d == 32'h0, "R1 ctrl", d, 0);
    rd(3'd1, d); check(d == 32'h100, "R1 status", d, 32'h100);
    rd(3'd2, d); check(d == 32'h0, "R1 mask", d, 0);
    rd(3'd5, d); check(d == 32'h0, "R1 rx", d, 0);
    check(!sck && !irq, "R1 pins", {30'h0, sck, irq}, 0);
  endtask

  task automatic t_order(input bit msb, input logic [3:0] len, input logic [31:0] t,
                         input logic [31:0] rp, input string tag);
    logic [31:0] rx, d, m;
    int n = nb(len);
    m = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
    xfer(1'b0, msb, len, 4'd0, t, rp, 1'b1, rx);
    check(cap_cnt == n, {tag, " R2 bit count"}, cap_cnt, n);
    check((cap & m) == exp_tx(t, n, msb), {tag, " R4 mosi order"}, cap & m, exp_tx(t, n, msb));
    check(rx == exp_rx(rp, n, msb), {tag, " R4/R6 rx"}, rx, exp_rx(rp, n, msb));
    rd(3'd1, d); check(d == 32'h300, {tag, " R8 flags"}, d, 32'h300);
  endtask

  task automatic t_period();
    logic [31:0] rx, d;
    wr(3'd0, ctl(1'b1, 1'b0, 1'b0, 4'd7, 4'd1));
    wr(3'd0, ctl(1'b1, 1'b0, 1'b1, 4'd7, 4'd1));
    last_rise = 0; period = 0;
    wr(3'd4, 32'h0000_0066);
    rd(3'd1, d); check(d[8] == 1'b0, "R8 free low while shifting", d, 0);
    wait_free();
    check(period == 8, "R5 period pm=1", period, 8);
    xfer(1'b1, 1'b0, 4'd7, 4'd3, 32'h11, 32'h0, 1'b1, rx);
    check(period == 16, "R5 period pm=3", period, 16);
    check(!sck, "R5 idle low", sck, 0);
  endtask

  task automatic t_loop();
    logic [31:0] rx;
    xfer(1'b1, 1'b1, 4'd11, 4'd0, 32'hFFFF_F9A5, 32'hFFFF_FFFF, 1'b1, rx);
    check(rx == 32'h9A5, "R7 loopback / R6 upper zero", rx, 32'h9A5);
  endtask

  task automatic t_w1c_irq();
    logic [31:0] d;
    wr(3'd2, 32'h0);
    check(!irq, "R10 all masked", irq, 0);
    wr(3'd2, 32'h200);
    check(irq, "R10 rx flag unmasked", irq, 1);
    wr(3'd1, 32'h0); rd(3'd1, d); check(d == 32'h300, "R9 zero write no effect", d, 32'h300);
    wr(3'd1, 32'h200); rd(3'd1, d); check(d == 32'h100, "R9 clear rx flag", d, 32'h100);
    check(!irq, "R10 irq drops", irq, 0);
    wr(3'd2, 32'h100);
    check(irq, "R10 tx flag unmasked", irq, 1);
    wr(3'd1, 32'h100); rd(3'd1, d); check(d == 32'h0, "R9 clear tx flag", d, 0);
    check(!irq, "R10 irq clear", irq, 0);
    wr(3'd2, 32'h0);
  endtask

  task automatic t_len_lock();
    logic [31:0] d;
    wr(3'd0, ctl(1'b0, 1'b0, 1'b0, 4'd5, 4'd0));
    wr(3'd0, ctl(1'b0, 1'b0, 1'b1, 4'd5, 4'd0));
    wr(3'd0, ctl(1'b0, 1'b1, 1'b1, 4'd9, 4'd2));
    rd(3'd0, d);
    check(d == ctl(1'b0, 1'b1, 1'b1, 4'd5, 4'd2), "R3 length frozen", d,
          ctl(1'b0, 1'b1, 1'b1, 4'd5, 4'd2));
  endtask

  task automatic t_ignore();
    logic [31:0] d, rx;
    int r0;
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd0, ctl(1'b1, 1'b0, 1'b0, 4'd7, 4'd0));
    r0 = rises;
    wr(3'd4, 32'h5A);
    repeat (60) @(negedge clk);
    rd(3'd1, d);
    check(rises == r0 && d == 32'h0, "R11 disabled write ignored", d, 0);
    wr(3'd0, ctl(1'b1, 1'b0, 1'b1, 4'd7, 4'd0) & ~(32'd1 << 25));
    wr(3'd4, 32'h5A);
    repeat (60) @(negedge clk);
    rd(3'd1, d);
    check(rises == r0 && d == 32'h0, "R11 non-master write ignored", d, 0);
    wr(3'd0, ctl(1'b1, 1'b0, 1'b1, 4'd7, 4'd3));
    r0 = rises;
    wr(3'd4, 32'h5A);
    wr(3'd4, 32'hC3);
    wait_free();
    rd(3'd5, rx);
    check(rx == 32'h5A && rises - r0 == 8, "R11 busy write ignored", rx, 32'h5A);
  endtask

  task automatic t_sticky();
    logic [31:0] d, rx;
    xfer(1'b1, 1'b0, 4'd7, 4'd0, 32'h3C, 32'h0, 1'b1, rx);
    rd(3'd5, d);
    rd(3'd1, d); check(d[9], "R12 read keeps rx flag", d, 32'h300);
    xfer(1'b1, 1'b0, 4'd7, 4'd0, 32'hE1, 32'h0, 1'b0, rx);
    check(rx == 32'hE1, "R12 overwrite", rx, 32'hE1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_order(1'b0, 4'd7,  32'hFFFF_FFA5, 32'h0000_003C, "lsb8");
    t_order(1'b1, 4'd15, 32'h0000_1234, 32'h0000_BEEF, "msb16");
    t_order(1'b0, 4'd0,  32'hDEAD_BEEF, 32'h0F1E_2D3C, "w32");
    t_order(1'b1, 4'd1,  32'h0000_0009, 32'h0000_0006, "min4");
    t_order(1'b0, 4'd3,  32'hFFFF_FFF2, 32'h0000_000D, "len4");
    t_period();
    t_loop();
    t_w1c_irq();
    t_len_lock();
    t_ignore();
    t_sticky();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule